// File: doc/BRIEF.md
# Shifter Operand Generator

This block forms the second ALU operand of a data-processing instruction, together with the carry bit that the shifter produces for the logical operations. It is pure combinational logic and holds no state. It sits between the register-read stage and the ALU, and its inputs come straight from instruction decode and the register file.

Three operand sources exist. The first takes a register and shifts it by an amount held in the instruction word. The second takes a register and shifts it by an amount read from the low byte of another register. The third takes a small constant from the instruction word and rotates it right by an even distance.

Each shift kind has its own boundary encodings. In the immediate-amount form, a zero amount stands for a long shift or for a rotate through the carry. In the register-amount form, a byte of 32 or more has its own result and carry rules. The carry-out for each case is written out in the requirements below.

Top module: `shifter_operand_gen`

## Requirements
- R1: Form code 0 selects immediate-amount shifting. Shift code 0 is logical left, 1 logical right, 2 arithmetic right and 3 rotate right. For a nonzero amount n, left shift gives carry bit (32-n) of the source. The right shifts and the rotate give carry bit (n-1). A left shift of zero passes the source through, with the carry equal to the incoming carry.
- R2: In form 0, a logical-right or arithmetic-right shift with amount zero acts as a shift by 32. The result is 0 for logical right and 32 copies of source bit 31 for arithmetic right. In both cases the carry is source bit 31.
- R3: In form 0, a rotate with amount zero shifts the source right by one and puts the incoming carry into bit 31. The carry-out is the old bit 0.
- R4: In form 0 only, when the register-is-PC flag is set, the source is the register value plus 4. Form 1 never adds this offset.
- R5: Form code 1 takes its amount from bits [7:0] of the amount register and ignores the upper bits. An amount byte of zero passes the register through for every shift code, with the carry equal to the incoming carry.
- R6: In form 1, a logical left or right shift by exactly 32 gives 0. The carry is bit 0 for the left shift and bit 31 for the right shift. An amount above 32 gives 0 with carry 0.
- R7: In form 1, an arithmetic right shift by 32 or more gives 32 copies of bit 31, with carry bit 31.
- R8: In form 1, a rotate uses only amount bits [3:0]. If the byte is nonzero and those four bits are zero, the register passes unchanged with carry bit 31. Otherwise the register rotates by bits [3:0], with carry bit (amount-1).
- R9: Form codes 2 and 3 zero-extend the 8-bit constant and rotate it right by twice the 4-bit rotate field. The carry is the incoming carry when the field is zero and result bit 31 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| form_sel | input | 2 | Operand form: 0 immediate-amount shift, 1 register-amount shift, 2 or 3 rotated constant |
| shift_kind | input | 2 | Shift code: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| imm_amt | input | 5 | Shift amount for form 0 |
| rot_fld | input | 4 | Rotate field for forms 2 and 3 |
| imm_const | input | 8 | Constant for forms 2 and 3 |
| rm_val | input | 32 | Value of the register being shifted |
| rs_val | input | 32 | Amount register for form 1; only bits [7:0] are used |
| rm_is_pc | input | 1 | The shifted register is the program counter |
| c_in | input | 1 | Current carry flag |
| op_out | output | 32 | Shifted operand |
| c_out | output | 1 | Shifter carry-out |

## Verification
Directed cases cover the zero-amount re-encodings of the immediate form:
- A design that treats them literally passes the source through for logical and arithmetic right shifts instead of flushing it.
- The same design rotates by zero instead of rotating through the carry.

In the register form, the amount bytes 32, 33, 48 and 255 are applied with the upper amount bits set:
- A design that uses more than the low byte shifts by the wrong amount.
- A design that clips the amount to 5 bits shifts by the wrong amount.
- A design that merges the exact-32 case with the above-32 case gives the wrong carry.

Rotates whose byte is nonzero but whose low nibble is zero must keep bit 31 as the carry. Every rotate field of the constant form is applied with both carry values. Random operands then cover all forms at once.

// File: rtl/shop_pkg.sv
package shop_pkg;

  typedef enum logic [1:0] {
    FORM_IMM_SHIFT = 2'd0,
    FORM_REG_SHIFT = 2'd1,
    FORM_ROT_CONST = 2'd2,
    FORM_ROT_ALT   = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  // Canonical operation after amount normalisation
  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_LSL  = 3'd1,
    OP_LSR  = 3'd2,
    OP_ASR  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RRX  = 3'd5,
    OP_ZERO = 3'd6
  } opkind_e;

endpackage

// File: rtl/shop_decode.sv
module shop_decode
  import shop_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SAMT_W = $clog2(DW),
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int RAMT_W = 8,
  parameter int RROT_W = 4,
  parameter int PC_ADJ = 4,
  parameter int AW     = SAMT_W + 1
) (
  input  logic [1:0]        form_i,
  input  logic [1:0]        kind_i,
  input  logic [SAMT_W-1:0] imm_amt_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic [IMM_W-1:0]  const_i,
  input  logic [DW-1:0]     rm_i,
  input  logic [DW-1:0]     rs_i,
  input  logic              rm_is_pc_i,
  output logic [DW-1:0]     src_o,
  output opkind_e           op_o,
  output logic [AW-1:0]     amt_o
);

  localparam logic [RAMT_W-1:0] FULL_B = RAMT_W'(DW);
  localparam logic [AW-1:0]     FULL_A = AW'(DW);

  logic [RAMT_W-1:0] amt_byte;
  logic [RROT_W-1:0] rot_nib;

  assign amt_byte = rs_i[RAMT_W-1:0];
  assign rot_nib  = amt_byte[RROT_W-1:0];

  always_comb begin
    src_o = rm_i;
    op_o  = OP_PASS;
    amt_o = '0;
    case (form_e'(form_i))
      FORM_IMM_SHIFT: begin
        src_o = rm_i + (rm_is_pc_i ? DW'(PC_ADJ) : '0);
        amt_o = AW'(imm_amt_i);
        case (shift_e'(kind_i))
          SH_LSL: op_o = (imm_amt_i == '0) ? OP_PASS : OP_LSL;
          SH_LSR: begin
            op_o = OP_LSR;
            if (imm_amt_i == '0) amt_o = FULL_A;
          end
          SH_ASR: begin
            op_o = OP_ASR;
            if (imm_amt_i == '0) amt_o = FULL_A;
          end
          default: op_o = (imm_amt_i == '0) ? OP_RRX : OP_ROR;
        endcase
      end
      FORM_REG_SHIFT: begin
        if (amt_byte != '0) begin
          case (shift_e'(kind_i))
            SH_LSL, SH_LSR: begin
              if (amt_byte > FULL_B) begin
                op_o = OP_ZERO;
              end else begin
                op_o  = (shift_e'(kind_i) == SH_LSL) ? OP_LSL : OP_LSR;
                amt_o = AW'(amt_byte);
              end
            end
            SH_ASR: begin
              op_o  = OP_ASR;
              amt_o = (amt_byte >= FULL_B) ? FULL_A : AW'(amt_byte);
            end
            default: begin
              op_o  = OP_ROR;
              amt_o = (rot_nib == '0) ? FULL_A : AW'(rot_nib);
            end
          endcase
        end
      end
      default: begin
        src_o = DW'(const_i);
        if (rot_i != '0) begin
          op_o  = OP_ROR;
          amt_o = AW'({rot_i, 1'b0});
        end
      end
    endcase
  end

endmodule

// File: rtl/shop_funnel.sv
module shop_funnel #(
  parameter int DW = 32,
  parameter int AW = $clog2(DW) + 1
) (
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  input  logic [AW-1:0] amt_i,
  output logic [DW-1:0] res_o,
  output logic          cry_o
);

  // {hi, lo, guard} shifted right; the guard slot catches the last bit out
  localparam int XW = 2 * DW + 1;

  logic [XW-1:0] stage [0:AW];

  assign stage[0] = {hi_i, lo_i, 1'b0};

  for (genvar g = 0; g < AW; g++) begin : g_stage
    assign stage[g+1] = amt_i[g] ? (stage[g] >> (1 << g)) : stage[g];
  end

  assign res_o = stage[AW][DW:1];
  assign cry_o = stage[AW][0];

endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
  import shop_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SAMT_W = $clog2(DW),
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int RAMT_W = 8,
  parameter int RROT_W = 4,
  parameter int PC_ADJ = 4
) (
  input  logic [1:0]        form_sel,
  input  logic [1:0]        shift_kind,
  input  logic [SAMT_W-1:0] imm_amt,
  input  logic [ROT_W-1:0]  rot_fld,
  input  logic [IMM_W-1:0]  imm_const,
  input  logic [DW-1:0]     rm_val,
  input  logic [DW-1:0]     rs_val,
  input  logic              rm_is_pc,
  input  logic              c_in,
  output logic [DW-1:0]     op_out,
  output logic              c_out
);

  localparam int AW = SAMT_W + 1;

  logic [DW-1:0] src, src_rev, fun_hi, fun_lo, fun_res, fun_res_rev;
  logic          fun_cry;
  opkind_e       op_k;
  logic [AW-1:0] amt;

  shop_decode #(
    .DW(DW), .SAMT_W(SAMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W),
    .RAMT_W(RAMT_W), .RROT_W(RROT_W), .PC_ADJ(PC_ADJ), .AW(AW)
  ) u_decode (
    .form_i    (form_sel),
    .kind_i    (shift_kind),
    .imm_amt_i (imm_amt),
    .rot_i     (rot_fld),
    .const_i   (imm_const),
    .rm_i      (rm_val),
    .rs_i      (rs_val),
    .rm_is_pc_i(rm_is_pc),
    .src_o     (src),
    .op_o      (op_k),
    .amt_o     (amt)
  );

  // Left shifts reuse the right funnel on a bit-reversed word
  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign src_rev[i]     = src[DW-1-i];
    assign fun_res_rev[i] = fun_res[DW-1-i];
  end

  always_comb begin
    fun_hi = '0;
    fun_lo = src;
    case (op_k)
      OP_LSL:  fun_lo = src_rev;
      OP_ASR:  fun_hi = {DW{src[DW-1]}};
      OP_ROR:  fun_hi = src;
      default: ;
    endcase
  end

  shop_funnel #(.DW(DW), .AW(AW)) u_funnel (
    .hi_i (fun_hi),
    .lo_i (fun_lo),
    .amt_i(amt),
    .res_o(fun_res),
    .cry_o(fun_cry)
  );

  always_comb begin
    case (op_k)
      OP_PASS: begin op_out = src;                  c_out = c_in;    end
      OP_ZERO: begin op_out = '0;                   c_out = 1'b0;    end
      OP_RRX:  begin op_out = {c_in, src[DW-1:1]};  c_out = src[0];  end
      OP_LSL:  begin op_out = fun_res_rev;          c_out = fun_cry; end
      default: begin op_out = fun_res;              c_out = fun_cry; end
    endcase
  end

endmodule

// File: rtl/shop_checker.sv
module shop_checker #(
  parameter int DW     = 32,
  parameter int SAMT_W = $clog2(DW),
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int RAMT_W = 8,
  parameter int RROT_W = 4
) (
  input logic [1:0]        form_sel,
  input logic [1:0]        shift_kind,
  input logic [SAMT_W-1:0] imm_amt,
  input logic [ROT_W-1:0]  rot_fld,
  input logic [IMM_W-1:0]  imm_const,
  input logic [DW-1:0]     rm_val,
  input logic [DW-1:0]     rs_val,
  input logic              rm_is_pc,
  input logic              c_in,
  input logic [DW-1:0]     op_out,
  input logic              c_out
);

  logic [RAMT_W-1:0] rbyte;
  assign rbyte = rs_val[RAMT_W-1:0];

  always_comb begin
    if (form_sel == 2'd0 && shift_kind == 2'd1 && imm_amt == '0 && !rm_is_pc)
      assert_lsr_zero_is_full_R2: assert (op_out == '0 && c_out == rm_val[DW-1])
        else $error("R2 immediate LSR by zero");

    if (form_sel == 2'd0 && shift_kind == 2'd3 && imm_amt == '0)
      assert_rrx_R3: assert (op_out[DW-1] == c_in && c_out == rm_val[0])
        else $error("R3 rotate through carry");

    if (form_sel == 2'd1 && rbyte == '0)
      assert_reg_zero_pass_R5: assert (op_out == rm_val && c_out == c_in)
        else $error("R5 zero register amount");

    if (form_sel == 2'd1 && !shift_kind[1] && rbyte > RAMT_W'(DW))
      assert_reg_over_full_R6: assert (op_out == '0 && !c_out)
        else $error("R6 logical shift beyond width");

    if (form_sel == 2'd1 && shift_kind == 2'd2 && rbyte >= RAMT_W'(DW))
      assert_asr_saturate_R7: assert (op_out == {DW{rm_val[DW-1]}} && c_out == rm_val[DW-1])
        else $error("R7 arithmetic shift saturation");

    if (form_sel == 2'd1 && shift_kind == 2'd3 && rbyte != '0 && rbyte[RROT_W-1:0] == '0)
      assert_ror_nibble_zero_R8: assert (op_out == rm_val && c_out == rm_val[DW-1])
        else $error("R8 rotate by multiple of sixteen");

    if (form_sel[1] && rot_fld == '0)
      assert_const_unrotated_R9: assert (op_out == DW'(imm_const) && c_out == c_in)
        else $error("R9 unrotated constant");
  end

endmodule

bind shifter_operand_gen shop_checker #(
  .DW(DW), .SAMT_W(SAMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W),
  .RAMT_W(RAMT_W), .RROT_W(RROT_W)
) u_shop_chk (
  .form_sel  (form_sel),
  .shift_kind(shift_kind),
  .imm_amt   (imm_amt),
  .rot_fld   (rot_fld),
  .imm_const (imm_const),
  .rm_val    (rm_val),
  .rs_val    (rs_val),
  .rm_is_pc  (rm_is_pc),
  .c_in      (c_in),
  .op_out    (op_out),
  .c_out     (c_out)
);

// File: tb/tb_shifter_operand_gen.sv
module tb_shifter_operand_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  form_sel;
  logic [1:0]  shift_kind;
  logic [4:0]  imm_amt;
  logic [3:0]  rot_fld;
  logic [7:0]  imm_const;
  logic [31:0] rm_val;
  logic [31:0] rs_val;
  logic        rm_is_pc;
  logic        c_in;
  logic [31:0] op_out;
  logic        c_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  shifter_operand_gen dut (
    .form_sel(form_sel), .shift_kind(shift_kind), .imm_amt(imm_amt),
    .rot_fld(rot_fld), .imm_const(imm_const), .rm_val(rm_val),
    .rs_val(rs_val), .rm_is_pc(rm_is_pc), .c_in(c_in),
    .op_out(op_out), .c_out(c_out)
  );

  function automatic logic [31:0] ror32(input logic [31:0] x, input int k);
    if (k == 0) return x;
    return (x >> k) | (x << (32 - k));
  endfunction

  // Expected {carry, operand} written from the requirements
  function automatic logic [32:0] model(
    input logic [1:0] f, input logic [1:0] t, input logic [4:0] a,
    input logic [3:0] rot, input logic [7:0] k, input logic [31:0] rm,
    input logic [31:0] rs, input logic pc, input logic c);
    logic [31:0] s, r;
    logic        co;
    int          n, b, q;
    if (f == 2'd0) begin
      s = pc ? rm + 32'd4 : rm;
      n = int'(a);
      case (t)
        2'd0: if (n == 0) begin r = s; co = c; end
              else begin r = s << n; co = s[32-n]; end
        2'd1: if (n == 0) begin r = 0; co = s[31]; end
              else begin r = s >> n; co = s[n-1]; end
        2'd2: if (n == 0) begin r = {32{s[31]}}; co = s[31]; end
              else begin r = 32'($signed(s) >>> n); co = s[n-1]; end
        default: if (n == 0) begin r = {c, s[31:1]}; co = s[0]; end
                 else begin r = ror32(s, n); co = s[n-1]; end
      endcase
    end else if (f == 2'd1) begin
      b = int'(rs[7:0]);
      if (b == 0) begin r = rm; co = c; end
      else case (t)
        2'd0: if (b < 32) begin r = rm << b; co = rm[32-b]; end
              else if (b == 32) begin r = 0; co = rm[0]; end
              else begin r = 0; co = 1'b0; end
        2'd1: if (b < 32) begin r = rm >> b; co = rm[b-1]; end
              else if (b == 32) begin r = 0; co = rm[31]; end
              else begin r = 0; co = 1'b0; end
        2'd2: if (b < 32) begin r = 32'($signed(rm) >>> b); co = rm[b-1]; end
              else begin r = {32{rm[31]}}; co = rm[31]; end
        default: begin
          q = b % 16;
          if (q == 0) begin r = rm; co = rm[31]; end
          else begin r = ror32(rm, q); co = rm[q-1]; end
        end
      endcase
    end else begin
      r  = ror32({24'd0, k}, 2 * int'(rot));
      co = (rot == 0) ? c : r[31];
    end
    return {co, r};
  endfunction

  function automatic string tag_of(input logic [1:0] f, input logic [1:0] t,
                                   input logic [4:0] a, input logic [31:0] rs,
                                   input logic pc);
    if (f[1]) return "R9";
    if (f == 2'd1) begin
      if (rs[7:0] == 0) return "R5";
      if (t == 2'd3) return "R8";
      if (rs[7:0] >= 32) return (t == 2'd2) ? "R7" : "R6";
      return "R5";
    end
    if (pc) return "R4";
    if (a == 0 && (t == 2'd1 || t == 2'd2)) return "R2";
    if (a == 0 && t == 2'd3) return "R3";
    return "R1";
  endfunction

  task automatic run_case(input logic [1:0] f, input logic [1:0] t, input logic [4:0] a,
                          input logic [3:0] rot, input logic [7:0] k,
                          input logic [31:0] rm, input logic [31:0] rs,
                          input logic pc, input logic c);
    logic [32:0] exp;
    string       tg;
    form_sel = f; shift_kind = t; imm_amt = a; rot_fld = rot; imm_const = k;
    rm_val = rm; rs_val = rs; rm_is_pc = pc; c_in = c;
    @(negedge clk);
    exp = model(f, t, a, rot, k, rm, rs, pc, c);
    tg  = tag_of(f, t, a, rs, pc);
    checks++;
    if ({c_out, op_out} !== exp) begin
      errors++;
      $display("FAIL %s form=%0d kind=%0d amt=%0d rs=%h rm=%h: got op=%h c=%0b, expected op=%h c=%0b",
               tg, f, t, a, rs, rm, op_out, c_out, exp[31:0], exp[32]);
    end
  endtask

  // Idle inputs all zero: operand 0, carry 0 (R1 pass-through)
  task automatic t_reset_state();
    run_case(2'd0, 2'd0, 5'd0, 4'd0, 8'd0, 32'd0, 32'd0, 1'b0, 1'b0);
  endtask

  // R1 R2 R3: immediate-amount shifts at edge and middle amounts
  task automatic t_imm_shift();
    int amts [5] = '{0, 1, 2, 16, 31};
    logic [31:0] vals [3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96};
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 5; i++)
        for (int v = 0; v < 3; v++)
          for (int c = 0; c < 2; c++)
            run_case(2'd0, 2'(t), 5'(amts[i]), 4'd0, 8'd0, vals[v], 32'hFFFF_FFFF, 1'b0, 1'(c));
  endtask

  // R4: PC offset in form 0 only
  task automatic t_pc_adjust();
    for (int t = 0; t < 4; t++) begin
      run_case(2'd0, 2'(t), 5'd0, 4'd0, 8'd0, 32'h0000_1FFC, 32'd0, 1'b1, 1'b1);
      run_case(2'd0, 2'(t), 5'd4, 4'd0, 8'd0, 32'hFFFF_FFFC, 32'd0, 1'b1, 1'b0);
      run_case(2'd1, 2'(t), 5'd0, 4'd0, 8'd0, 32'h0000_1FFC, 32'd3, 1'b1, 1'b0);
    end
  endtask

  // R5 R6 R7 R8: register amounts with upper amount bits set
  task automatic t_reg_shift();
    int bytes [11] = '{0, 1, 15, 16, 31, 32, 33, 48, 64, 128, 255};
    logic [31:0] vals [3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'h9E37_79B9};
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 11; i++)
        for (int v = 0; v < 3; v++)
          for (int c = 0; c < 2; c++)
            run_case(2'd1, 2'(t), 5'd7, 4'd0, 8'd0, vals[v],
                     {24'hC3A500, 8'(bytes[i])}, 1'b0, 1'(c));
  endtask

  // R9: every rotate field, both form codes, both carries
  task automatic t_rot_const();
    for (int f = 2; f < 4; f++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 2; c++) begin
          run_case(2'(f), 2'd0, 5'd0, 4'(r), 8'hC5, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'(c));
          run_case(2'(f), 2'd3, 5'd3, 4'(r), 8'h7E, 32'd0, 32'd0, 1'b1, 1'(c));
        end
  endtask

  // Mixed random stimulus across all forms (R1, R5, R9 and the rest)
  task automatic t_random();
    for (int i = 0; i < 3000; i++)
      run_case(2'($urandom), 2'($urandom), 5'($urandom), 4'($urandom), 8'($urandom),
               $urandom, ((i % 3) == 0) ? 32'($urandom % 40) : $urandom,
               1'($urandom), 1'($urandom));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    form_sel = '0; shift_kind = '0; imm_amt = '0; rot_fld = '0; imm_const = '0;
    rm_val = '0; rs_val = '0; rm_is_pc = 1'b0; c_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_imm_shift();
    t_pc_adjust();
    t_reg_shift();
    t_rot_const();
    t_random();
    finish_run();
  end

endmodule